// File: doc/BRIEF.md
# Transmit Interrupt Delay Controller

This block sits between a transmit descriptor engine and the interrupt logic. The engine reports each descriptor it has finished with a one-cycle completion pulse. The pulse carries two flags: report-status, which asks for an interrupt, and delay-enable, which asks that the interrupt be held back. The block collects completions into write-back batches and raises one sticky write-back cause bit. The cause is raised either at once or when one of two countdown timers runs out.

Software programs four things through a small word-addressed write port: a per-packet delay reload, an absolute delay reload, a batch threshold and a mask enable. It clears the cause by writing one to the clear bit. With delays in use, a driver that queues frames one at a time gets one interrupt after a burst of frames instead of one per frame.

Top module: `txirq_delay_ctrl`

## Requirements
- R1: A completion with report-status set and delay-enable clear sets `cause` and pulses `wb_req` at the first rising edge that samples it.
- R2: Completions are counted and written back as one batch. `wb_req` pulses with `wb_cnt` equal to the batch size when the count reaches the threshold (address 2; a value of 0 acts as 1). A `wb_flush` cycle writes back any pending count.
- R3: A completion with report-status set forces an immediate write-back. The batch holds every pending completion plus that completion.
- R4: A completion with both flags set does not raise `cause` at once. With per-packet reload P (address 0) non-zero, `cause` rises P edges after the edge that sampled the completion.
- R5: Each further delayed completion reloads the per-packet timer, so `cause` rises P edges after the last one.
- R6: The absolute timer (reload A at address 1) loads only when it is idle. Further delayed completions do not restart it, so `cause` rises A edges after the first delayed completion.
- R7: A reload of 0 disables that timer. When both reloads are 0, a delayed completion behaves as in R1.
- R8: When either timer fires, both timers return to idle. A timer that did not fire raises no later cause.
- R9: `cause` is sticky. A write to address 3 with bit 1 set clears it. A set and a clear in the same cycle leave it set.
- R10: `irq` equals `cause` ANDed with the mask-enable bit (address 3 bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_valid | input | 1 | One-cycle descriptor completion pulse |
| cmpl_rs | input | 1 | Report-status flag of the completion |
| cmpl_ide | input | 1 | Delay-enable flag of the completion |
| wb_flush | input | 1 | Write back any pending completions |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address |
| cfg_wdata | input | CFG_W | Configuration write data |
| wb_req | output | 1 | Write-back request pulse |
| wb_cnt | output | TH_W | Number of descriptors in the write-back |
| cause | output | 1 | Sticky write-back interrupt cause |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench builds the block with an 8-bit timer width and a 4-bit threshold width. This keeps every timer window short enough to count edge by edge. It also makes the largest threshold, 15, cheap to fill: the full batch at that limit is driven and checked. A table walks the flag and reload combinations for a single completion and records the edge on which `cause` rises. Directed cases then cover per-packet restart, absolute no-restart, the two timers stopping each other, and a clear that lands in the same cycle as a set.

// File: rtl/txirq_pkg.sv
// Package: shared constants and types for the transmit interrupt delay controller.
// Assumes the configuration port is word-addressed with a 2-bit address.
package txirq_pkg;

    // Configuration word addresses
    localparam logic [1:0] ADDR_PKT_RELOAD = 2'd0;
    localparam logic [1:0] ADDR_ABS_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_WB_THRESH  = 2'd2;
    localparam logic [1:0] ADDR_CTRL       = 2'd3;

    // Bit positions within the control word
    localparam int CTRL_MASK_BIT = 0;
    localparam int CTRL_CLR_BIT  = 1;

    // Countdown timer flavour
    typedef enum logic {
        TMR_PER_PKT  = 1'b0,
        TMR_ABSOLUTE = 1'b1
    } tmr_mode_e;

endpackage

// File: rtl/txirq_regs.sv
// Module: configuration registers for the transmit interrupt delay controller.
// Holds both timer reloads, the batch threshold and the mask enable. Decodes
// the write-one-to-clear strobe for the cause bit.
// Assumes TMR_W and TH_W are not larger than CFG_W.
module txirq_regs
    import txirq_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int TMR_W = 16,
    parameter int TH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [TMR_W-1:0] pkt_reload,
    output logic [TMR_W-1:0] abs_reload,
    output logic [TH_W-1:0]  wb_thresh,
    output logic             mask_en,
    output logic             cause_clr
);

    // Register file write: each word is loaded when its address is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_reload <= '0;
            abs_reload <= '0;
            wb_thresh  <= TH_W'(1);
            mask_en    <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_PKT_RELOAD: pkt_reload <= cfg_wdata[TMR_W-1:0];
                ADDR_ABS_RELOAD: abs_reload <= cfg_wdata[TMR_W-1:0];
                ADDR_WB_THRESH:  wb_thresh  <= cfg_wdata[TH_W-1:0];
                default:         mask_en    <= cfg_wdata[CTRL_MASK_BIT];
            endcase
        end
    end

    // Clear strobe: a write of one to the clear bit of the control word
    always_comb begin
        cause_clr = cfg_we && (cfg_addr == ADDR_CTRL) && cfg_wdata[CTRL_CLR_BIT];
    end

endmodule

// File: rtl/txirq_wb_batch.sv
// Module: write-back batcher. Counts completed descriptors and emits one
// write-back request with the batch size. A request is sent when the count
// reaches the threshold, when a report-status completion arrives, or on a
// flush while completions are pending.
// Assumes a threshold of 0 means 1. The pending count stays below the
// threshold, so it never overflows TH_W bits.
module txirq_wb_batch #(
    parameter int TH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmpl_valid,
    input  logic            cmpl_rs,
    input  logic            flush,
    input  logic [TH_W-1:0] thresh,
    output logic            wb_req,
    output logic [TH_W-1:0] wb_cnt
);

    logic [TH_W-1:0] pend;
    logic [TH_W-1:0] thr_eff;
    logic [TH_W-1:0] total;
    logic            send;
    logic [TH_W-1:0] send_cnt;

    // Next batch size and the decision whether to send it
    always_comb begin
        thr_eff  = (thresh == '0) ? TH_W'(1) : thresh;
        total    = cmpl_valid ? pend + TH_W'(1) : pend;
        send     = 1'b0;
        send_cnt = total;
        if (cmpl_valid && (cmpl_rs || (total >= thr_eff))) begin
            send = 1'b1;
        end else if (flush && (total != '0)) begin
            send = 1'b1;
        end
    end

    // Pending counter and registered write-back request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            wb_req <= 1'b0;
            wb_cnt <= '0;
        end else begin
            wb_req <= send;
            if (send) begin
                wb_cnt <= send_cnt;
                pend   <= '0;
            end else begin
                pend   <= total;
            end
        end
    end

    AST_WB_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_cnt != '0)); // R2
    AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pend != '1); // R2

endmodule

// File: rtl/txirq_timer.sv
// Module: one countdown timer for delayed interrupts.
// MODE selects the flavour. A per-packet timer reloads on every load request.
// An absolute timer loads only while idle and then runs to zero untouched.
// A reload of zero disables the timer. Stop, driven by the other timer's fire,
// returns the timer to idle and takes priority over a load in the same cycle.
// Fire is a one-cycle pulse in the cycle that the count reaches its end.
module txirq_timer
    import txirq_pkg::*;
#(
    parameter int        TMR_W = 16,
    parameter tmr_mode_e MODE  = TMR_PER_PKT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] reload,
    input  logic             load,
    input  logic             stop,
    output logic             fire,
    output logic             running
);

    logic [TMR_W-1:0] cnt;
    logic             do_load;

    // Load gating depends on the timer flavour
    generate
        if (MODE == TMR_PER_PKT) begin : g_restart
            always_comb do_load = load && (reload != '0);
        end else begin : g_oneshot
            always_comb do_load = load && (reload != '0) && !running;
        end
    endgenerate

    // Expiry: the last count, unless a restart replaces it this cycle
    always_comb begin
        fire = running && (cnt == TMR_W'(1)) && !do_load;
    end

    // Countdown state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (stop || fire) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (do_load) begin
            running <= 1'b1;
            cnt     <= reload;
        end else if (running) begin
            cnt     <= cnt - TMR_W'(1);
        end
    end

    AST_TMR_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0)); // R4

    generate
        if (MODE == TMR_ABSOLUTE) begin : g_abs_chk
            AST_ABS_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                (running && !stop && !fire) |=> (running && (cnt == $past(cnt) - TMR_W'(1)))); // R6
        end
    endgenerate

endmodule

// File: rtl/txirq_delay_ctrl.sv
// Module: transmit interrupt delay controller (top).
// Turns descriptor completions into a sticky write-back cause. The cause is
// raised at once, or after a per-packet or an absolute countdown, and the
// masked interrupt line is driven from it. Write-backs are batched.
// Assumes completion pulses last one cycle. The delay-enable flag is not
// expected in per-vector message mode; behaviour there is undefined.
module txirq_delay_ctrl
    import txirq_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int TMR_W = 16,
    parameter int TH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_valid,
    input  logic             cmpl_rs,
    input  logic             cmpl_ide,
    input  logic             wb_flush,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             wb_req,
    output logic [TH_W-1:0]  wb_cnt,
    output logic             cause,
    output logic             irq
);

    localparam int NUM_TMR = 2;

    logic [TMR_W-1:0]   pkt_reload;
    logic [TMR_W-1:0]   abs_reload;
    logic [TH_W-1:0]    wb_thresh;
    logic               mask_en;
    logic               cause_clr;
    logic               delays_off;
    logic               imm_hit;
    logic               dly_hit;
    logic [NUM_TMR-1:0] tmr_fire;
    logic [NUM_TMR-1:0] tmr_run;
    logic [TMR_W-1:0]   tmr_reload [NUM_TMR];

    txirq_regs #(
        .CFG_W (CFG_W),
        .TMR_W (TMR_W),
        .TH_W  (TH_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .pkt_reload (pkt_reload),
        .abs_reload (abs_reload),
        .wb_thresh  (wb_thresh),
        .mask_en    (mask_en),
        .cause_clr  (cause_clr)
    );

    txirq_wb_batch #(
        .TH_W (TH_W)
    ) u_batch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmpl_valid (cmpl_valid),
        .cmpl_rs    (cmpl_rs),
        .flush      (wb_flush),
        .thresh     (wb_thresh),
        .wb_req     (wb_req),
        .wb_cnt     (wb_cnt)
    );

    // Classify a report-status completion as immediate or delayed
    always_comb begin
        delays_off = (pkt_reload == '0) && (abs_reload == '0);
        imm_hit    = cmpl_valid && cmpl_rs && (!cmpl_ide || delays_off);
        dly_hit    = cmpl_valid && cmpl_rs && cmpl_ide && !delays_off;
        tmr_reload[0] = pkt_reload;
        tmr_reload[1] = abs_reload;
    end

    // Timer 0 restarts per packet, timer 1 is absolute; each stops the other
    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            localparam tmr_mode_e MODE_I = (i == 0) ? TMR_PER_PKT : TMR_ABSOLUTE;
            txirq_timer #(
                .TMR_W (TMR_W),
                .MODE  (MODE_I)
            ) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .reload  (tmr_reload[i]),
                .load    (dly_hit),
                .stop    (tmr_fire[NUM_TMR-1-i]),
                .fire    (tmr_fire[i]),
                .running (tmr_run[i])
            );
        end
    endgenerate

    // Sticky cause: any set source wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= 1'b0;
        end else if (imm_hit || (|tmr_fire)) begin
            cause <= 1'b1;
        end else if (cause_clr) begin
            cause <= 1'b0;
        end
    end

    // Masked interrupt line
    always_comb begin
        irq = cause && mask_en;
    end

    AST_CAUSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause) |-> $past(imm_hit || (|tmr_fire))); // R1
    AST_IMM_WRITES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        imm_hit |=> wb_req); // R1
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !cause_clr) |=> cause); // R9
    AST_TIMERS_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_fire) |=> (tmr_run == '0)); // R8
    AST_DELAYED_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_hit && !cause && !(|tmr_fire) && !(|tmr_run)) |=> !cause); // R4

endmodule

// File: tb/sim_txirq_delay_ctrl.sv
module sim_txirq_delay_ctrl;

    localparam int CFG_W = 16;
    localparam int TMR_W = 8;
    localparam int TH_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmpl_valid = 1'b0;
    logic             cmpl_rs = 1'b0;
    logic             cmpl_ide = 1'b0;
    logic             wb_flush = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             wb_req;
    logic [TH_W-1:0]  wb_cnt;
    logic             cause;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    txirq_delay_ctrl #(
        .CFG_W (CFG_W),
        .TMR_W (TMR_W),
        .TH_W  (TH_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_rs(cmpl_rs),
        .cmpl_ide(cmpl_ide), .wb_flush(wb_flush), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .wb_req(wb_req),
        .wb_cnt(wb_cnt), .cause(cause), .irq(irq)
    );

    // Vector: {rs, ide, pkt reload, abs reload, edge on which cause rises (0 = never)}
    localparam int NV = 7;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd5, 8'd9, 8'd1},   // R1 immediate
        {1'b1, 1'b1, 8'd5, 8'd9, 8'd6},   // R4 per-packet first
        {1'b1, 1'b1, 8'd0, 8'd4, 8'd5},   // R7 per-packet disabled, absolute only
        {1'b1, 1'b1, 8'd0, 8'd0, 8'd1},   // R7 both disabled -> immediate
        {1'b0, 1'b1, 8'd3, 8'd3, 8'd0},   // R4 no report-status -> no cause
        {1'b1, 1'b1, 8'd3, 8'd7, 8'd4},   // R4 per-packet shorter
        {1'b1, 1'b1, 8'd9, 8'd2, 8'd3}    // R6 absolute shorter
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input int d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(d);
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cmpl(input logic rs, input logic ide);
        cmpl_valid = 1'b1; cmpl_rs = rs; cmpl_ide = ide;
        tick();
        cmpl_valid = 1'b0; cmpl_rs = 1'b0; cmpl_ide = 1'b0;
    endtask

    task automatic clear_cause();
        reg_wr(2'd3, 3);   // keep mask on, clear cause
    endtask

    // Measure the edge (counting the completion edge as 1) where cause rises
    task automatic measure(output int got);
        int n = 1;
        while (!cause && n < 40) begin
            tick();
            n++;
        end
        got = cause ? n : 0;
    endtask

    initial begin
        int got;
        tick(); tick(); tick();
        chk("R9 reset cause", int'(cause), 0);
        chk("R10 reset irq", int'(irq), 0);
        chk("R2 reset wb_req", int'(wb_req), 0);
        rst_n = 1'b1;
        tick();

        // Table walk: timing of cause for each flag/reload combination
        reg_wr(2'd3, 1);
        for (int i = 0; i < NV; i++) begin
            reg_wr(2'd0, int'(VEC[i][23:16]));
            reg_wr(2'd1, int'(VEC[i][15:8]));
            clear_cause();
            cmpl(VEC[i][25], VEC[i][24]);
            measure(got);
            chk($sformatf("R4/R7 vector %0d cause edge", i), got, int'(VEC[i][7:0]));
            repeat (12) tick();
        end

        // R10 mask
        reg_wr(2'd0, 0); reg_wr(2'd1, 0);
        clear_cause();
        reg_wr(2'd3, 0);
        cmpl(1'b1, 1'b0);
        chk("R1 immediate cause", int'(cause), 1);
        chk("R10 masked irq", int'(irq), 0);
        reg_wr(2'd3, 1);
        chk("R10 unmasked irq", int'(irq), 1);

        // R9 sticky, clear, and set beating clear
        repeat (5) tick();
        chk("R9 sticky", int'(cause), 1);
        clear_cause();
        chk("R9 clear", int'(cause), 0);
        cmpl_valid = 1'b1; cmpl_rs = 1'b1;
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'd3;
        tick();
        cmpl_valid = 1'b0; cmpl_rs = 1'b0; cfg_we = 1'b0;
        chk("R9 set wins over clear", int'(cause), 1);
        clear_cause();

        // R2 batching at threshold 3
        reg_wr(2'd2, 3);
        cmpl(1'b0, 1'b0);
        chk("R2 no wb after 1", int'(wb_req), 0);
        cmpl(1'b0, 1'b0);
        chk("R2 no wb after 2", int'(wb_req), 0);
        cmpl(1'b0, 1'b0);
        chk("R2 wb at threshold", int'(wb_req), 1);
        chk("R2 wb count 3", int'(wb_cnt), 3);
        chk("R2 no cause from plain", int'(cause), 0);
        // R2 flush
        cmpl(1'b0, 1'b0);
        cmpl(1'b0, 1'b0);
        wb_flush = 1'b1; tick(); wb_flush = 1'b0;
        chk("R2 flush wb", int'(wb_req), 1);
        chk("R2 flush count", int'(wb_cnt), 2);
        tick();
        wb_flush = 1'b1; tick(); wb_flush = 1'b0;
        chk("R2 flush with nothing pending", int'(wb_req), 0);
        // R2 threshold 0 acts as 1
        reg_wr(2'd2, 0);
        cmpl(1'b0, 1'b0);
        chk("R2 thresh0 wb", int'(wb_req), 1);
        chk("R2 thresh0 count", int'(wb_cnt), 1);
        // R2 largest threshold
        reg_wr(2'd2, 15);
        for (int k = 0; k < 14; k++) cmpl(1'b0, 1'b0);
        chk("R2 no wb at 14 of 15", int'(wb_req), 0);
        cmpl(1'b0, 1'b0);
        chk("R2 wb count 15", int'(wb_cnt), 15);
        // R3 report-status forces write-back
        reg_wr(2'd2, 5);
        cmpl(1'b0, 1'b0);
        cmpl(1'b0, 1'b0);
        cmpl(1'b1, 1'b0);
        chk("R3 rs wb", int'(wb_req), 1);
        chk("R3 rs wb count", int'(wb_cnt), 3);
        clear_cause();

        // R5 per-packet restart
        reg_wr(2'd0, 6); reg_wr(2'd1, 0);
        cmpl(1'b1, 1'b1);
        tick(); tick();
        chk("R4 delayed not immediate", int'(cause), 0);
        cmpl(1'b1, 1'b1);
        measure(got);
        chk("R5 restart edge", got, 7);
        clear_cause();
        repeat (10) tick();

        // R6 absolute does not restart
        reg_wr(2'd0, 0); reg_wr(2'd1, 8);
        cmpl(1'b1, 1'b1);
        tick(); tick();
        cmpl(1'b1, 1'b1);
        tick(); tick();
        cmpl(1'b1, 1'b1);
        chk("R6 before expiry n7", int'(cause), 0);
        tick();
        chk("R6 before expiry n8", int'(cause), 0);
        tick();
        chk("R6 expiry n9", int'(cause), 1);
        clear_cause();
        repeat (10) tick();

        // R8 absolute fires, per-packet must stop too
        reg_wr(2'd0, 10); reg_wr(2'd1, 4);
        cmpl(1'b1, 1'b1);
        repeat (4) tick();
        chk("R8 absolute fired", int'(cause), 1);
        clear_cause();
        repeat (15) tick();
        chk("R8 per-packet stopped", int'(cause), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule